// File: doc/BRIEF.md
# Configurable Serial Audio Frame Transmitter

This block turns parallel audio words into a three-wire serial stream made of a bit clock, a frame sync and one data line. It is always the clock master. The bit clock is derived from the system clock by a fixed division ratio, and each frame carries one or more word slots.

A small set of static format controls selects the framing:
- word length and number of slots per frame;
- a sync pulse that lasts a whole word or only one bit;
- sync that leads the first data bit by one bit clock, or starts with it;
- sync polarity and bit-clock polarity;
- MSB-first or LSB-first shifting;
- a per-slot mask.

With these controls one serialiser produces the common two-channel word-select framings and the short-pulse DSP framings. The format inputs must only change while `tx_active` is low.

Words arrive on a valid/ready stream. `s_ready` is high for exactly one system cycle at the start of each unmasked slot, and a word is taken in that cycle when `s_valid` is also high. The source may hold `s_valid` low as long as it likes. If it does so at the moment a word is due, the slot is sent as zeros, no word is taken and `underrun` pulses. When `tx_enable` falls, the block finishes the frame in progress and then goes idle.

Top module: `audio_frame_tx`

## Requirements
- R1: The bit clock period is BCLK_DIV system cycles. `sdata` and `fsync` change only on the launch edge of the bit clock, which is falling when `cfg_bclk_invert`=0 and rising when it is 1. While idle, `bclk` rests at the level opposite the launch level.
- R2: With `cfg_lsb_first`=0, the first bit sent of a word is bit `cfg_word_len`-1, followed by descending indices. With `cfg_lsb_first`=1, bit 0 is sent first, followed by ascending indices.
- R3: A frame is `cfg_slot_count` (1..MAX_SLOTS) slots of `cfg_word_len` (2..DATA_W) bits each. Every start from idle is preceded by one lead bit clock whose data is 0.
- R4: With `cfg_sync_word`=1, sync is active for the whole of slot 0. With `cfg_sync_word`=0, sync is active for a single bit clock only.
- R5: With `cfg_sync_early`=1, the sync window is moved one bit clock earlier: it covers the last bit of the previous frame, or the lead bit for the first frame. After the final frame it is not asserted.
- R6: Active sync drives `fsync` high when `cfg_sync_active_low`=0 and low when it is 1. Inactive sync drives the opposite level.
- R7: `s_ready` is high only while `tx_active` is high, for one cycle at the start of each unmasked slot. A word transfers when `s_valid` and `s_ready` are both high.
- R8: A slot whose bit in `cfg_slot_mask` is 1, or whose index is at or above `cfg_slot_count`, takes no word and drives `sdata` low for the whole slot.
- R9: If a word is due and `s_valid` is low, the slot is sent as zeros, no word is taken, and `underrun` is high for exactly one cycle, the cycle after the due cycle.
- R10: After `tx_enable` falls, `tx_active` stays high and frames continue until the frame in progress is complete. Then `tx_active` falls and no further bits are sent.
- R11: While idle, `sdata` is 0 and `fsync` sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Start transmitting; on release, stop at frame end |
| cfg_word_len | input | $clog2(DATA_W+1) | Bits per word slot |
| cfg_slot_count | input | $clog2(MAX_SLOTS+1) | Slots per frame |
| cfg_sync_word | input | 1 | 1: sync lasts slot 0; 0: one bit clock |
| cfg_sync_early | input | 1 | Sync leads the frame by one bit clock |
| cfg_sync_active_low | input | 1 | Active level of fsync is low |
| cfg_bclk_invert | input | 1 | Launch edge is rising instead of falling |
| cfg_lsb_first | input | 1 | Shift bit 0 first |
| cfg_slot_mask | input | MAX_SLOTS | 1 suppresses the slot |
| s_valid | input | 1 | Stream word available |
| s_ready | output | 1 | Word is taken this cycle if valid |
| s_data | input | DATA_W | Stream word, right-aligned |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| tx_active | output | 1 | Transmitter running |
| underrun | output | 1 | One-cycle pulse when a due word was missing |

## Verification
`tx_active` rises one cycle after `tx_enable` is first seen high, and the first launch edge follows one cycle later. Every launch edge updates `sdata`, `fsync` and `bclk` in the same register stage. The sampling edge then comes BCLK_DIV/2 cycles later, and the next launch edge BCLK_DIV cycles after the previous one. `s_ready` is combinational in the launch cycle of a slot's first bit, and `underrun` follows one cycle later.

The bench does not predict absolute cycle numbers. It captures `sdata` and `fsync` at every receiver sampling edge, at the falling edge of the system clock. It compares the captured sequence, and the spacing of those edges, with values computed from the requirements. It counts transferred words and underrun pulses. Finally, it checks that `tx_active` stays high after `tx_enable` is released and that no sampling edge appears once the block has stopped.

// File: rtl/afx_pkg.sv
package afx_pkg;

  typedef struct packed {
    logic sync_word;
    logic sync_early;
    logic sync_low;
    logic bclk_inv;
    logic lsb_first;
  } afx_fmt_t;

  // Unpolarised sync state for the bit about to be launched.
  function automatic logic afx_sync_active(
    input afx_fmt_t f,
    input logic     lead,
    input logic     in_slot0,
    input logic     at_bit0,
    input logic     last_bit,
    input logic     last_slot,
    input logic     more
  );
    logic cur_slot0, cur_bit0, nxt_slot0, nxt_bit0;
    cur_slot0 = !lead && in_slot0;
    cur_bit0  = cur_slot0 && at_bit0;
    nxt_bit0  = lead || (last_bit && last_slot && more);
    nxt_slot0 = lead || (last_bit ? (last_slot && more) : in_slot0);
    if (f.sync_early) return f.sync_word ? nxt_slot0 : nxt_bit0;
    return f.sync_word ? cur_slot0 : cur_bit0;
  endfunction

endpackage

// File: rtl/afx_bclk_gen.sv
module afx_bclk_gen #(
  parameter int BCLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic launch,
  input  logic launch_lvl,
  output logic bit_edge,
  output logic bclk
);
  localparam int DIV_W = (BCLK_DIV > 2) ? $clog2(BCLK_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(BCLK_DIV - 1);
  localparam logic [DIV_W-1:0] HALF = DIV_W'(BCLK_DIV / 2);

  logic [DIV_W-1:0] cnt;

  assign bit_edge = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b1;
    end else if (!run) begin
      cnt  <= '0;
      bclk <= !launch_lvl;
    end else begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (launch)
        bclk <= launch_lvl;
      else if (cnt == HALF)
        bclk <= !launch_lvl;
    end
  end
endmodule

// File: rtl/afx_slot_seq.sv
module afx_slot_seq
  import afx_pkg::*;
#(
  parameter int MAX_SLOTS = 2,
  parameter int LEN_W     = 6,
  parameter int SLOT_W    = 2,
  parameter int BIT_W     = 5,
  parameter int SIDX_W    = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_enable,
  input  logic                 bit_edge,
  input  logic [LEN_W-1:0]     cfg_word_len,
  input  logic [SLOT_W-1:0]    cfg_slot_count,
  input  logic [MAX_SLOTS-1:0] cfg_slot_mask,
  input  afx_fmt_t             fmt,
  output logic                 running,
  output logic                 launch,
  output logic                 slot_live,
  output logic                 fetch,
  output logic                 fs_pin,
  output logic [BIT_W-1:0]     bit_idx
);
  logic [SIDX_W-1:0] slot_idx;
  logic lead, halt_q;
  logic last_bit, last_slot, frame_end, act;

  assign last_bit  = LEN_W'(bit_idx) == (cfg_word_len - LEN_W'(1));
  assign last_slot = SLOT_W'(slot_idx) == (cfg_slot_count - SLOT_W'(1));
  assign frame_end = !lead && last_bit && last_slot;
  assign launch    = bit_edge && !halt_q;
  assign slot_live = !lead && !cfg_slot_mask[slot_idx]
                     && (SLOT_W'(slot_idx) < cfg_slot_count);
  assign fetch     = launch && slot_live && (bit_idx == '0);
  assign act       = afx_sync_active(fmt, lead, slot_idx == '0, bit_idx == '0,
                                     last_bit, last_slot, tx_enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      halt_q   <= 1'b0;
      lead     <= 1'b0;
      bit_idx  <= '0;
      slot_idx <= '0;
      fs_pin   <= 1'b0;
    end else if (!running) begin
      halt_q   <= 1'b0;
      fs_pin   <= fmt.sync_low;
      bit_idx  <= '0;
      slot_idx <= '0;
      if (tx_enable) begin
        running <= 1'b1;
        lead    <= 1'b1;
      end
    end else if (bit_edge) begin
      if (halt_q) begin
        running <= 1'b0;
        halt_q  <= 1'b0;
      end else begin
        fs_pin <= act ^ fmt.sync_low;
        if (lead) begin
          lead <= 1'b0;
        end else if (last_bit) begin
          bit_idx <= '0;
          if (last_slot) begin
            slot_idx <= '0;
            if (!tx_enable) halt_q <= 1'b1;
          end else begin
            slot_idx <= slot_idx + 1'b1;
          end
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end

  logic unused_end;
  assign unused_end = frame_end;
endmodule

// File: rtl/afx_word_path.sv
module afx_word_path #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6,
  parameter int BIT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic              launch,
  input  logic              fetch,
  input  logic              live,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic [LEN_W-1:0]  cfg_word_len,
  input  logic              cfg_lsb_first,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              sdata,
  output logic              underrun
);
  logic [DATA_W-1:0] word_q, sel_word;
  logic [BIT_W-1:0]  pick;

  assign sel_word = fetch ? (s_valid ? s_data : '0) : word_q;
  assign pick     = cfg_lsb_first ? bit_idx
                  : BIT_W'(cfg_word_len - LEN_W'(1) - LEN_W'(bit_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      sdata    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= fetch && !s_valid;
      if (fetch) word_q <= sel_word;
      if (!running)
        sdata <= 1'b0;
      else if (launch)
        sdata <= live ? sel_word[pick] : 1'b0;
    end
  end
endmodule

// File: rtl/audio_frame_tx.sv
module audio_frame_tx
  import afx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_SLOTS = 2,
  parameter int BCLK_DIV  = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 tx_enable,
  input  logic [$clog2(DATA_W+1)-1:0]          cfg_word_len,
  input  logic [$clog2(MAX_SLOTS+1)-1:0]       cfg_slot_count,
  input  logic                                 cfg_sync_word,
  input  logic                                 cfg_sync_early,
  input  logic                                 cfg_sync_active_low,
  input  logic                                 cfg_bclk_invert,
  input  logic                                 cfg_lsb_first,
  input  logic [MAX_SLOTS-1:0]                 cfg_slot_mask,
  input  logic                                 s_valid,
  output logic                                 s_ready,
  input  logic [DATA_W-1:0]                    s_data,
  output logic                                 bclk,
  output logic                                 fsync,
  output logic                                 sdata,
  output logic                                 tx_active,
  output logic                                 underrun
);
  localparam int LEN_W  = $clog2(DATA_W + 1);
  localparam int SLOT_W = $clog2(MAX_SLOTS + 1);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int SIDX_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;

  afx_fmt_t fmt;
  logic running, launch, bit_edge, live, fetch;
  logic [BIT_W-1:0] bit_idx;

  assign fmt = '{sync_word:  cfg_sync_word,  sync_early: cfg_sync_early,
                 sync_low:   cfg_sync_active_low, bclk_inv: cfg_bclk_invert,
                 lsb_first:  cfg_lsb_first};

  afx_bclk_gen #(.BCLK_DIV(BCLK_DIV)) u_bclk (
    .clk(clk), .rst_n(rst_n), .run(running), .launch(launch),
    .launch_lvl(cfg_bclk_invert), .bit_edge(bit_edge), .bclk(bclk)
  );

  afx_slot_seq #(
    .MAX_SLOTS(MAX_SLOTS), .LEN_W(LEN_W), .SLOT_W(SLOT_W),
    .BIT_W(BIT_W), .SIDX_W(SIDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .bit_edge(bit_edge),
    .cfg_word_len(cfg_word_len), .cfg_slot_count(cfg_slot_count),
    .cfg_slot_mask(cfg_slot_mask), .fmt(fmt), .running(running),
    .launch(launch), .slot_live(live), .fetch(fetch), .fs_pin(fsync),
    .bit_idx(bit_idx)
  );

  afx_word_path #(.DATA_W(DATA_W), .LEN_W(LEN_W), .BIT_W(BIT_W)) u_word (
    .clk(clk), .rst_n(rst_n), .running(running), .launch(launch),
    .fetch(fetch), .live(live), .bit_idx(bit_idx),
    .cfg_word_len(cfg_word_len), .cfg_lsb_first(cfg_lsb_first),
    .s_valid(s_valid), .s_data(s_data), .sdata(sdata), .underrun(underrun)
  );

  assign s_ready   = fetch;
  assign tx_active = running;
endmodule

// File: rtl/afx_tx_checker.sv
module afx_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic bclk,
  input logic fsync,
  input logic sdata,
  input logic tx_active,
  input logic underrun,
  input logic s_valid,
  input logic s_ready,
  input logic cfg_bclk_invert,
  input logic cfg_sync_active_low
);
  p_ready_when_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> tx_active);

  p_underrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(s_ready && !s_valid));

  p_underrun_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  p_data_on_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !$stable(sdata)) |-> (bclk == cfg_bclk_invert));

  p_sync_on_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !$stable(fsync)) |-> (bclk == cfg_bclk_invert));

  p_idle_levels_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && $past(!tx_active) && $past(rst_n)
     && $stable(cfg_sync_active_low) && $stable(cfg_bclk_invert))
    |-> (!sdata && fsync == cfg_sync_active_low && bclk == !cfg_bclk_invert));
endmodule

bind audio_frame_tx afx_tx_checker u_afx_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdata(sdata),
  .tx_active(tx_active), .underrun(underrun), .s_valid(s_valid),
  .s_ready(s_ready), .cfg_bclk_invert(cfg_bclk_invert),
  .cfg_sync_active_low(cfg_sync_active_low)
);

// File: tb/sim_audio_frame_tx.sv
module sim_audio_frame_tx;
  localparam int DATA_W = 32;
  localparam int MAX_SLOTS = 2;
  localparam int DIV = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tx_enable, s_valid, s_ready, bclk, fsync, sdata, tx_active, underrun;
  logic [5:0] cfg_word_len;
  logic [1:0] cfg_slot_count, cfg_slot_mask;
  logic cfg_sync_word, cfg_sync_early, cfg_sync_active_low, cfg_bclk_invert, cfg_lsb_first;
  logic [DATA_W-1:0] s_data;

  audio_frame_tx #(.DATA_W(DATA_W), .MAX_SLOTS(MAX_SLOTS), .BCLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .cfg_word_len(cfg_word_len),
    .cfg_slot_count(cfg_slot_count), .cfg_sync_word(cfg_sync_word),
    .cfg_sync_early(cfg_sync_early), .cfg_sync_active_low(cfg_sync_active_low),
    .cfg_bclk_invert(cfg_bclk_invert), .cfg_lsb_first(cfg_lsb_first),
    .cfg_slot_mask(cfg_slot_mask), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .bclk(bclk), .fsync(fsync), .sdata(sdata),
    .tx_active(tx_active), .underrun(underrun)
  );

  int nchk = 0, nerr = 0;
  logic finished = 1'b0;

  // stream source
  logic [DATA_W-1:0] src_mem [0:15];
  int src_cnt = 0, src_idx = 0;
  logic src_clr = 1'b0;
  assign s_valid = (src_idx < src_cnt) && (src_idx < 16);
  assign s_data  = s_valid ? src_mem[src_idx] : '0;
  always @(posedge clk) begin
    if (src_clr) src_idx <= 0;
    else if (s_valid && s_ready) src_idx <= src_idx + 1;
  end

  // receiver-side capture at the sampling edge
  logic cap_d [0:255];
  logic cap_f [0:255];
  int cap_n = 0, urun_n = 0, per_err = 0, last_t = 0, cyc = 0;
  logic cap_clr = 1'b0, prev_bclk = 1'b1;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (cap_clr) begin
      cap_n = 0; urun_n = 0; per_err = 0;
    end else begin
      if (underrun) urun_n = urun_n + 1;
      if (bclk !== prev_bclk && bclk == !cfg_bclk_invert) begin
        if (cap_n > 0 && (cyc - last_t) != DIV) per_err = per_err + 1;
        last_t = cyc;
        if (cap_n < 256) begin
          cap_d[cap_n] = sdata;
          cap_f[cap_n] = fsync;
        end
        cap_n = cap_n + 1;
      end
    end
    prev_bclk <= bclk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input int w, input int s, input bit sw, input bit early,
                          input bit low, input bit inv, input bit lsb,
                          input logic [1:0] mask, input int avail, input int nf);
    int nbits, total, u, exp_words, guard, after;
    int dmis, fmis, d_act, d_exp, f_act, f_exp, d_at, f_at;
    @(negedge clk);
    cap_clr = 1'b1; src_clr = 1'b1;
    cfg_word_len = 6'(w); cfg_slot_count = 2'(s); cfg_sync_word = sw;
    cfg_sync_early = early; cfg_sync_active_low = low; cfg_bclk_invert = inv;
    cfg_lsb_first = lsb; cfg_slot_mask = mask; src_cnt = avail;
    for (int k = 0; k < 16; k++)
      src_mem[k] = (32'h6B1D_3A95 * (k + 3)) ^ (32'(w) << 20);
    repeat (3) @(negedge clk);
    cap_clr = 1'b0; src_clr = 1'b0;
    nbits = s * w;
    total = 1 + nf * nbits;
    tx_enable = 1'b1;
    guard = 0;
    while (cap_n < 2 + (nf - 1) * nbits && guard < 20000) begin
      @(negedge clk); guard++;
    end
    tx_enable = 1'b0;
    @(negedge clk);
    chk(tx_active == 1'b1, "R10", "active after enable drop", int'(tx_active), 1);
    guard = 0;
    while (tx_active && guard < 20000) begin @(negedge clk); guard++; end
    after = cap_n;
    repeat (4 * DIV) @(negedge clk);
    chk(cap_n == after, "R10", "bits after stop", cap_n - after, 0);
    chk(cap_n == total, "R3", "bits sent", cap_n, total);
    chk(per_err == 0, "R1", "bit clock period errors", per_err, 0);

    u = 0;
    for (int k = 0; k < s; k++) if (!mask[k]) u++;
    dmis = 0; fmis = 0; d_act = 0; d_exp = 0; f_act = 0; f_exp = 0; d_at = 0; f_at = 0;
    for (int i = 0; i < total && i < 256; i++) begin
      bit ed, ef, act;
      ed = 1'b0;
      if (i == 0) begin
        act = early;
      end else begin
        int j, f, b, sl, k, rank, wn, nb;
        j = i - 1; f = j / nbits; b = j % nbits; sl = b / w; k = b % w;
        if (!mask[sl]) begin
          rank = 0;
          for (int q = 0; q < sl; q++) if (!mask[q]) rank++;
          wn = f * u + rank;
          if (wn < avail) ed = src_mem[wn][lsb ? k : (w - 1 - k)];
        end
        if (early) begin
          nb = (j + 1) % nbits;
          act = (j + 1 < nf * nbits) && (sw ? (nb / w == 0) : (nb == 0));
        end else begin
          act = sw ? (sl == 0) : (b == 0);
        end
      end
      ef = act ^ low;
      if (cap_d[i] !== ed) begin
        if (dmis == 0) begin d_act = int'(cap_d[i]); d_exp = int'(ed); d_at = i; end
        dmis++;
      end
      if (cap_f[i] !== ef) begin
        if (fmis == 0) begin f_act = int'(cap_f[i]); f_exp = int'(ef); f_at = i; end
        fmis++;
      end
    end
    chk(dmis == 0, "R2/R8/R9", $sformatf("data bit %0d", d_at), d_act, d_exp);
    chk(fmis == 0, "R4/R5/R6", $sformatf("sync bit %0d", f_at), f_act, f_exp);
    exp_words = (u * nf < avail) ? u * nf : avail;
    chk(src_idx == exp_words, "R7", "words taken", src_idx, exp_words);
    chk(urun_n == u * nf - exp_words, "R9", "underrun pulses", urun_n, u * nf - exp_words);
    chk(sdata == 1'b0 && fsync == low, "R11", "idle sdata/fsync",
        int'({sdata, fsync}), int'({1'b0, low}));
  endtask

  task automatic t_reset;
    chk(bclk == 1'b1, "R1", "reset bclk", int'(bclk), 1);
    chk(fsync == 1'b0, "R11", "reset fsync", int'(fsync), 0);
    chk(sdata == 1'b0, "R11", "reset sdata", int'(sdata), 0);
    chk(tx_active == 1'b0, "R10", "reset active", int'(tx_active), 0);
    chk(s_ready == 1'b0, "R7", "reset ready", int'(s_ready), 0);
    chk(underrun == 1'b0, "R9", "reset underrun", int'(underrun), 0);
  endtask

  // word-long early active-low sync, MSB first (R4 R5 R6 R2)
  task automatic t_word_early_low;  run_case(16, 2, 1, 1, 1, 0, 0, 2'b00, 4, 2); endtask
  // word-long sync with first bit, inverted bit clock (R1 R4)
  task automatic t_word_late_inv;   run_case(8, 2, 1, 0, 0, 1, 0, 2'b00, 6, 3); endtask
  // one-bit early sync, LSB first (R5 R2)
  task automatic t_pulse_early_lsb; run_case(12, 2, 0, 1, 0, 0, 1, 2'b00, 4, 2); endtask
  // one-bit sync, single slot so slot 1 is beyond the count (R3 R8)
  task automatic t_pulse_mono;      run_case(10, 1, 0, 0, 0, 1, 0, 2'b00, 3, 3); endtask
  // slot 1 masked (R8)
  task automatic t_mask_slot;       run_case(8, 2, 1, 0, 1, 0, 0, 2'b10, 4, 2); endtask
  // source runs dry (R9)
  task automatic t_underrun;        run_case(8, 2, 0, 0, 0, 0, 1, 2'b00, 1, 2); endtask

  initial begin
    rst_n = 1'b0; tx_enable = 1'b0;
    cfg_word_len = 6'd16; cfg_slot_count = 2'd2; cfg_sync_word = 1'b1;
    cfg_sync_early = 1'b0; cfg_sync_active_low = 1'b0; cfg_bclk_invert = 1'b0;
    cfg_lsb_first = 1'b0; cfg_slot_mask = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_early_low();
    t_word_late_inv();
    t_pulse_early_lsb();
    t_pulse_mono();
    t_mask_slot();
    t_underrun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule